// File: doc/BRIEF.md
# Staged Integer Clock Divider Bank

The block derives four slower clocks from a single fast source clock. Each channel has its own integer divisor and its own enable select, and each can be held in soft reset on its own. The channels are intended for a bus clock, a coherency-port clock, a trace clock and a debug peripheral clock. A field value `n` selects a ratio of `n+1`. The divided output is high for the first `floor((n+1)/2)` source cycles of each period.

Software writes new divisors into staging registers. Writing a staging register has no effect on the running clocks. A separate trigger write copies every staged divisor into the active set in a single step. Each channel then adopts its new active ratio only when it wraps. A period that is already under way is therefore never cut short.

Registers are written through a single-cycle strobe with an address and a data word. The block has no read path.

Top module: `clkdiv_bank`

## Requirements
- R1: A channel running with active field `n >= 1` produces a periodic output with a period of `n+1` source cycles. The output is high for the first `floor((n+1)/2)` cycles of each period.
- R2: After `rst_n` is released, the active and staged divisor fields are 1, 1, 4 and 11 for channels 0 to 3. These give ratios 2, 2, 5 and 12.
- R3: A write to address `i` (0 to 3) loads bits [7:0] of the data word into the staged divisor of channel `i`. The running ratio does not change until a trigger is issued.
- R4: A write to address 4 with data bit 0 set raises the trigger. On the next clock edge all staged values are copied to the active set, and the trigger clears. Staging writes made later are not applied without another trigger.
- R5: A channel switches to a new active ratio only when its count wraps, at the end of its current period.
- R6: Address 5 holds a 2-bit enable select per channel, at bits [2i+1:2i]. Only the value 3 lets the clock out. The values 0, 1 and 2 hold the output low, while the counter keeps running.
- R7: Address 6 bit `i` is the active-low soft reset of channel `i`, and it is 0 after `rst_n`. While the bit is low, the counter and the output of that channel stay at zero. On release, a full period starts with the current active ratio.
- R8: An active field of 0 passes the source clock straight to the output, gated only by the enable select and the soft reset.
- R9: A write to address 7 changes nothing.
- R10: While `rst_n` is low, all outputs are low, all enables are off, all soft resets are asserted and no trigger is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock that all channels divide |
| rst_n | input | 1 | Asynchronous active-low reset of the whole bank |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| div_clk | output | 4 | Divided clock outputs, one bit per channel |

## Verification
Two events can fall in the same cycle. The first is the apply edge of a trigger coinciding with a channel's wrap: the channel must then take the value that was active before the copy, not the staged one. The second is a new staging write landing in the apply cycle itself: the copy must take the older staged value, and the new one must wait for the next trigger. The bench provokes both by issuing the trigger while channels of several ratios are at different counts, and by placing a staging write in the strobe cycle right after the trigger write. A behavioural reference model advances every channel's position on each edge and compares all four outputs, which judges both cases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Divisor field loaded at reset for each channel index.
  function automatic int unsigned dflt_div(input int unsigned ch);
    case (ch)
      0, 1:    return 1;
      2:       return 4;
      default: return 11;
    endcase
  endfunction

  // Number of high source cycles in one period for divisor field n.
  function automatic int unsigned high_len(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int N_CH   = 4,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [N_CH*DIV_W-1:0]   stg_flat,
  output logic [N_CH*DIV_W-1:0]   act_flat,
  output logic [2*N_CH-1:0]       en_sel,
  output logic [N_CH-1:0]         srst_n,
  output logic                    trig_q,
  output logic                    trig_set
);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(N_CH);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(N_CH + 1);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(N_CH + 2);

  logic [DIV_W-1:0] stg [N_CH];
  logic [DIV_W-1:0] act [N_CH];
  logic             unused_hi;

  assign unused_hi = ^wr_data;
  assign trig_set  = wr_en && (wr_addr == A_TRIG) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) begin
        stg[i] <= DIV_W'(clkdiv_pkg::dflt_div(i));
        act[i] <= DIV_W'(clkdiv_pkg::dflt_div(i));
      end
      en_sel <= '0;
      srst_n <= '0;
      trig_q <= 1'b0;
    end else begin
      if (trig_q) begin
        for (int i = 0; i < N_CH; i++) act[i] <= stg[i];
      end
      trig_q <= trig_set;
      if (wr_en) begin
        for (int i = 0; i < N_CH; i++) begin
          if (wr_addr == ADDR_W'(i)) stg[i] <= wr_data[DIV_W-1:0];
        end
        if (wr_addr == A_EN)   en_sel <= wr_data[2*N_CH-1:0];
        if (wr_addr == A_SRST) srst_n <= wr_data[N_CH-1:0];
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_flat
    assign stg_flat[g*DIV_W +: DIV_W] = stg[g];
    assign act_flat[g*DIV_W +: DIV_W] = act[g];
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_n,
  input  logic [1:0]       en_sel,
  input  logic [DIV_W-1:0] act_div,
  output logic             div_clk,
  output logic [DIV_W-1:0] run_o,
  output logic             wrap_o,
  output logic             phase_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] run;
  logic             fresh;
  logic             phase;
  logic             wrap;
  logic             en_ok;

  assign wrap  = fresh || (cnt == run);
  assign en_ok = (en_sel == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run   <= '0;
      fresh <= 1'b1;
      phase <= 1'b0;
    end else if (!srst_n) begin
      cnt   <= '0;
      run   <= act_div;
      fresh <= 1'b1;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      run   <= act_div;
      fresh <= 1'b0;
      phase <= clkdiv_pkg::high_len(32'(act_div)) != 0;
    end else begin
      cnt   <= cnt + ONE;
      phase <= (32'(cnt) + 32'd1) < clkdiv_pkg::high_len(32'(run));
    end
  end

  assign div_clk = en_ok && srst_n && ((run == '0) ? clk : phase);
  assign run_o   = run;
  assign wrap_o  = wrap;
  assign phase_o = phase;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int N_CH   = 4,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_CH-1:0]   div_clk
);
  logic [N_CH*DIV_W-1:0] stg_flat;
  logic [N_CH*DIV_W-1:0] act_flat;
  logic [N_CH*DIV_W-1:0] run_flat;
  logic [2*N_CH-1:0]     en_sel;
  logic [N_CH-1:0]       srst_n;
  logic [N_CH-1:0]       wrap;
  logic [N_CH-1:0]       phase;
  logic                  trig_q;
  logic                  trig_set;

  clkdiv_regs #(
    .N_CH(N_CH), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stg_flat(stg_flat), .act_flat(act_flat),
    .en_sel(en_sel), .srst_n(srst_n), .trig_q(trig_q), .trig_set(trig_set)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    clkdiv_chan #(.DIV_W(DIV_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .srst_n(srst_n[g]),
      .en_sel(en_sel[2*g +: 2]), .act_div(act_flat[g*DIV_W +: DIV_W]),
      .div_clk(div_clk[g]), .run_o(run_flat[g*DIV_W +: DIV_W]),
      .wrap_o(wrap[g]), .phase_o(phase[g])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int N_CH  = 4,
  parameter int DIV_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trig_q,
  input logic                  trig_set,
  input logic [N_CH*DIV_W-1:0] stg_flat,
  input logic [N_CH*DIV_W-1:0] act_flat,
  input logic [N_CH*DIV_W-1:0] run_flat,
  input logic [N_CH-1:0]       srst_n,
  input logic [N_CH-1:0]       wrap,
  input logic [N_CH-1:0]       phase
);
  // R4: a pending trigger is gone one edge later unless re-requested
  a_r4_trig_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q && !trig_set |=> !trig_q);

  // R4: the apply edge copies the staged set as it stood before that edge
  a_r4_apply_copies: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> act_flat == $past(stg_flat));

  // R3: without a pending trigger the active set does not move
  a_r3_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_q |=> $stable(act_flat));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R5: a running channel keeps its ratio until it wraps
    a_r5_switch_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      srst_n[g] && !wrap[g] |=> $stable(run_flat[g*DIV_W +: DIV_W]));

    // R7: a channel in soft reset has its phase at zero on the next edge
    a_r7_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !srst_n[g] |=> !phase[g]);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.N_CH(N_CH), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_q(trig_q), .trig_set(trig_set),
  .stg_flat(stg_flat), .act_flat(act_flat), .run_flat(run_flat),
  .srst_n(srst_n), .wrap(wrap), .phase(phase)
);

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  div_clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string req   = "R10";

  // behavioural reference state
  int m_stg [4];
  int m_act [4];
  int m_en  [4];
  int m_sr  [4];
  int pos   [4];
  int rat   [4];
  bit m_trig;

  clkdiv_bank i_clkdiv_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_clk(div_clk)
  );

  always #2 clk = ~clk;

  function automatic int def_val(input int ch);
    if (ch < 2) return 1;
    if (ch == 2) return 4;
    return 11;
  endfunction

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_stg[c] = def_val(c); m_act[c] = def_val(c);
        m_en[c] = 0; m_sr[c] = 0; pos[c] = -1; rat[c] = 0;
      end
      m_trig = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (m_sr[c] == 0) begin
          pos[c] = -1; rat[c] = m_act[c];
        end else if (pos[c] < 0 || pos[c] == rat[c]) begin
          pos[c] = 0; rat[c] = m_act[c];
        end else begin
          pos[c] = pos[c] + 1;
        end
      end
      if (m_trig) for (int c = 0; c < 4; c++) m_act[c] = m_stg[c];
      m_trig = wr_en && wr_addr == 3'd4 && wr_data[0];
      if (wr_en) begin
        if (wr_addr < 3'd4) m_stg[wr_addr] = int'(wr_data[7:0]);
        if (wr_addr == 3'd5) for (int c = 0; c < 4; c++) m_en[c] = int'(wr_data[2*c +: 2]);
        if (wr_addr == 3'd6) for (int c = 0; c < 4; c++) m_sr[c] = int'(wr_data[c]);
      end
    end
    for (int c = 0; c < 4; c++) begin
      bit exp;
      exp = (m_en[c] == 3) && (m_sr[c] == 1) &&
            (rat[c] == 0 || (pos[c] >= 0 && pos[c] < (rat[c] + 1) / 2));
      n_vec++;
      if (div_clk[c] !== exp) begin
        n_bad++;
        $display("FAIL %s ch%0d t=%0t actual=%b expected=%b", req, c, $time, div_clk[c], exp);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    req = "R10"; idle(4);
    @(negedge clk); rst_n = 1'b1;
    req = "R2";  wr(6, 'hF); wr(5, 'hFF); idle(60);          // defaults 2,2,5,12 (R1)
    req = "R3";  wr(0, 3); idle(30);                          // staged only
    req = "R5";  wr(4, 1); idle(40);                          // apply mid-period
    req = "R4";  wr(1, 6); idle(30);                          // no re-apply after self-clear
    req = "R6";  wr(5, 'hEF); idle(20); wr(5, 'h5F); idle(20); wr(5, 'hFF); idle(10);
    req = "R7";  wr(6, 'h7); wr(3, 2); wr(4, 1); idle(10); wr(6, 'hF); idle(20);
    req = "R8";  wr(2, 0); wr(4, 1); idle(20);
    req = "R9";  wr(7, 'hFFFF); idle(20);
    req = "R4";                                                 // staging write in the apply cycle
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd1;
    @(negedge clk); wr_addr = 3'd0; wr_data = 16'd1;
    @(negedge clk); wr_en = 1'b0; idle(30);
    wr(4, 1); idle(20);
    req = "R1";  wr(0, 9); wr(1, 2); wr(4, 1); idle(40);
    req = "R10"; @(negedge clk); rst_n = 1'b0; idle(3); @(negedge clk); rst_n = 1'b1; idle(5);
    req = "R2";  wr(6, 'hF); wr(5, 'hFF); idle(30);
    done = 1;
    finish_run();
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule